// File: doc/BRIEF.md
# Taken-Path Instruction Cache for the Fetch Stage

This block is a small, fully associative store in the fetch stage. It remembers branches that were last resolved as taken. For each such branch it keeps the first instruction word on the taken path and the address of the instruction that comes after that word. Every fetch cycle the current fetch address is compared with all stored branch addresses. On a hit, the block sends the stored instruction word to the decoder in place of the word from the instruction cache. It also sends the stored follow-on address out as the next fetch address. The decoder therefore has useful work while the instruction cache is still delivering the target line, so the multi-cycle cache latency after a taken branch is hidden.

On a miss, the block is transparent. The instruction cache word and the sequential next address pass straight through. Branch resolution drives a separate update port. A taken branch that is not stored gets a slot, and the victim slot is chosen in round-robin order. A taken branch that is already stored has its fields rewritten. A branch found not taken has its slot invalidated. Lookup is combinational. Updates land on the next clock edge and are not forwarded to a lookup in the same cycle.

Top module: `taken_path_cache`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every slot. After reset, no lookup hits until a taken update has been written.
- R2: On a miss, hit is 0, dec_insn equals ic_insn and next_fetch_addr equals seq_next_addr in the same cycle.
- R3: After a taken update for address A, a lookup of A in a later cycle hits. It returns the written target word on dec_insn and the written follow-on address on next_fetch_addr, in the same cycle as that lookup.
- R4: A hit needs an exact match on all ADDR_W bits. An address that differs in any bit from every stored address misses.
- R5: A not-taken update for a stored address invalidates that slot, and the next lookup of that address misses. Other slots keep their contents.
- R6: A not-taken update for an address that is not stored changes no slot.
- R7: A taken update for an address that is already stored rewrites that slot in place. It uses no new slot and evicts nothing.
- R8: Allocation takes slots in round-robin order, starting at slot 0 after reset. The pointer advances only on an allocation, and never on a rewrite or an invalidation. A freed slot is therefore reused only when the pointer reaches it.
- R9: An update does not affect a lookup made in the same cycle. That lookup sees the contents from before the update.
- R10: No address is ever stored in more than one slot, so a single not-taken update always removes it.
- R11: The default configuration holds four entries. Four distinct taken branches can all be held at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_addr | input | ADDR_W | Current instruction fetch address |
| ic_insn | input | INSN_W | Word read from the instruction cache this cycle |
| seq_next_addr | input | ADDR_W | Sequential next fetch address |
| hit | output | 1 | Lookup matched a valid slot |
| dec_insn | output | INSN_W | Word sent to the decoder |
| next_fetch_addr | output | ADDR_W | Address used for the next fetch |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_taken | input | 1 | The resolved branch was taken |
| upd_branch_addr | input | ADDR_W | Address of the resolved branch |
| upd_target_insn | input | INSN_W | First instruction word on the taken path |
| upd_cont_addr | input | ADDR_W | Address following that target word |

## Verification
A wrong valid bit or a wrong stored address shows at the ports in the first cycle in which that address is fetched again. It appears as a false hit, which replaces the cache word and the sequential address, or as a missed hit, which passes them through. A slot with a corrupted field returns the wrong word or follow-on address in that same combinational cycle. A round-robin pointer that is off by one stays hidden until the cache is full. It then shows one allocation later, as the wrong older branch disappearing, so the bench fills the cache and checks which entry is evicted.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   // kind of change an update-port beat makes to the slot array
   typedef enum logic [1:0] {
      UPD_IDLE    = 2'd0,
      UPD_ALLOC   = 2'd1,
      UPD_REFRESH = 2'd2,
      UPD_DROP    = 2'd3
   } upd_kind_e;

   function automatic upd_kind_e classify_update(input logic valid,
                                                 input logic taken,
                                                 input logic present);
      upd_kind_e k;
      if (!valid)          k = UPD_IDLE;
      else if (taken)      k = present ? UPD_REFRESH : UPD_ALLOC;
      else if (present)    k = UPD_DROP;
      else                 k = UPD_IDLE;
      return k;
   endfunction

endpackage

// File: rtl/tpc_entry_array.sv
module tpc_entry_array #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 32,
   parameter int INSN_W  = 32,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              lk_addr,
   input  logic [ADDR_W-1:0]              up_addr,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [INSN_W-1:0]              wr_insn,
   input  logic [ADDR_W-1:0]              wr_cont,
   input  logic                           clr_en,
   input  logic [IDX_W-1:0]               clr_idx,
   output logic [ENTRIES-1:0]             lk_match,
   output logic [ENTRIES-1:0]             up_match,
   output logic [ENTRIES-1:0][INSN_W-1:0] ent_insn,
   output logic [ENTRIES-1:0][ADDR_W-1:0] ent_cont
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic              vld_q;
      logic [ADDR_W-1:0] tag_q;
      logic [INSN_W-1:0] insn_q;
      logic [ADDR_W-1:0] cont_q;
      logic              sel_wr;
      logic              sel_clr;

      assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(e));
      assign sel_clr = clr_en && (clr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n)       vld_q <= 1'b0;
         else if (sel_wr)  vld_q <= 1'b1;
         else if (sel_clr) vld_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (sel_wr) begin
            tag_q  <= up_addr;
            insn_q <= wr_insn;
            cont_q <= wr_cont;
         end
      end

      assign lk_match[e] = vld_q && (tag_q == lk_addr);
      assign up_match[e] = vld_q && (tag_q == up_addr);
      assign ent_insn[e] = insn_q;
      assign ent_cont[e] = cont_q;
   end

endmodule

// File: rtl/tpc_rr_ptr.sv
module tpc_rr_ptr #(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam bit POW2   = ((ENTRIES & (ENTRIES - 1)) == 0)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] ptr_q;

   if (POW2) begin : g_natural_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)       ptr_q <= '0;
         else if (advance) ptr_q <= ptr_q + 1'b1;
      end
   end else begin : g_compare_wrap
      localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
      always_ff @(posedge clk) begin
         if (!rst_n)       ptr_q <= '0;
         else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/tpc_steer.sv
module tpc_steer #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 32,
   parameter int INSN_W  = 32
) (
   input  logic [ENTRIES-1:0]             lk_match,
   input  logic [ENTRIES-1:0][INSN_W-1:0] ent_insn,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_cont,
   input  logic [INSN_W-1:0]              ic_insn,
   input  logic [ADDR_W-1:0]              seq_addr,
   output logic                           hit,
   output logic [INSN_W-1:0]              dec_insn,
   output logic [ADDR_W-1:0]              next_addr
);

   logic [INSN_W-1:0] sel_insn;
   logic [ADDR_W-1:0] sel_cont;

   // and-or reduction: at most one match line is high
   always_comb begin
      sel_insn = '0;
      sel_cont = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         sel_insn = sel_insn | (ent_insn[e] & {INSN_W{lk_match[e]}});
         sel_cont = sel_cont | (ent_cont[e] & {ADDR_W{lk_match[e]}});
      end
   end

   assign hit       = |lk_match;
   assign dec_insn  = hit ? sel_insn : ic_insn;
   assign next_addr = hit ? sel_cont : seq_addr;

endmodule

// File: rtl/taken_path_cache.sv
module taken_path_cache #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 32,
   parameter int INSN_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [INSN_W-1:0] ic_insn,
   input  logic [ADDR_W-1:0] seq_next_addr,
   output logic              hit,
   output logic [INSN_W-1:0] dec_insn,
   output logic [ADDR_W-1:0] next_fetch_addr,
   input  logic              upd_valid,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_branch_addr,
   input  logic [INSN_W-1:0] upd_target_insn,
   input  logic [ADDR_W-1:0] upd_cont_addr
);
   import tpc_pkg::*;

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("taken_path_cache: ENTRIES must be at least 2");
   end
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
      $error("taken_path_cache: ADDR_W out of range 2..64");
   end
   if (INSN_W < 8) begin : g_bad_insn
      $error("taken_path_cache: INSN_W must be at least 8");
   end

   logic [ENTRIES-1:0]             lk_match;
   logic [ENTRIES-1:0]             up_match;
   logic [ENTRIES-1:0][INSN_W-1:0] ent_insn;
   logic [ENTRIES-1:0][ADDR_W-1:0] ent_cont;
   logic [IDX_W-1:0]               up_idx;
   logic [IDX_W-1:0]               vic_idx;
   logic [IDX_W-1:0]               wr_idx;
   logic                           wr_en;
   logic                           clr_en;
   logic                           alloc;
   upd_kind_e                      kind;

   always_comb begin
      up_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (up_match[e]) up_idx = up_idx | IDX_W'(e);
      end
   end

   assign kind = classify_update(upd_valid, upd_taken, |up_match);

   always_comb begin
      wr_en  = 1'b0;
      clr_en = 1'b0;
      alloc  = 1'b0;
      wr_idx = vic_idx;
      unique case (kind)
         UPD_ALLOC: begin
            wr_en = 1'b1;
            alloc = 1'b1;
         end
         UPD_REFRESH: begin
            wr_en  = 1'b1;
            wr_idx = up_idx;
         end
         UPD_DROP:  clr_en = 1'b1;
         default:   ;
      endcase
   end

   tpc_entry_array #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W),
      .INSN_W  (INSN_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_addr  (fetch_addr),
      .up_addr  (upd_branch_addr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_insn  (upd_target_insn),
      .wr_cont  (upd_cont_addr),
      .clr_en   (clr_en),
      .clr_idx  (up_idx),
      .lk_match (lk_match),
      .up_match (up_match),
      .ent_insn (ent_insn),
      .ent_cont (ent_cont)
   );

   tpc_rr_ptr #(
      .ENTRIES (ENTRIES)
   ) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (alloc),
      .ptr     (vic_idx)
   );

   tpc_steer #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W),
      .INSN_W  (INSN_W)
   ) u_steer (
      .lk_match  (lk_match),
      .ent_insn  (ent_insn),
      .ent_cont  (ent_cont),
      .ic_insn   (ic_insn),
      .seq_addr  (seq_next_addr),
      .hit       (hit),
      .dec_insn  (dec_insn),
      .next_addr (next_fetch_addr)
   );

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 32,
   parameter int INSN_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  fetch_addr,
   input logic [INSN_W-1:0]  ic_insn,
   input logic [ADDR_W-1:0]  seq_next_addr,
   input logic               hit,
   input logic [INSN_W-1:0]  dec_insn,
   input logic [ADDR_W-1:0]  next_fetch_addr,
   input logic               upd_valid,
   input logic               upd_taken,
   input logic [ADDR_W-1:0]  upd_branch_addr,
   input logic [INSN_W-1:0]  upd_target_insn,
   input logic [ADDR_W-1:0]  upd_cont_addr,
   input logic [ENTRIES-1:0] lk_match
);

   // R1: first cycle out of reset never hits
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit);

   // R2: miss passes the cache word and the sequential address through
   a_r2_miss_transparent: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (dec_insn == ic_insn) && (next_fetch_addr == seq_next_addr));

   // R3: a taken update is visible to a lookup of that address one cycle later
   a_r3_taken_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         ((fetch_addr != $past(upd_branch_addr)) ||
          (hit && dec_insn == $past(upd_target_insn) &&
           next_fetch_addr == $past(upd_cont_addr))));

   // R5: a not-taken update removes the address one cycle later
   a_r5_not_taken_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=>
         ((fetch_addr != $past(upd_branch_addr)) || !hit));

   // R10: never more than one slot matches a lookup
   a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

endmodule

bind taken_path_cache tpc_checker #(
   .ENTRIES (ENTRIES),
   .ADDR_W  (ADDR_W),
   .INSN_W  (INSN_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fetch_addr      (fetch_addr),
   .ic_insn         (ic_insn),
   .seq_next_addr   (seq_next_addr),
   .hit             (hit),
   .dec_insn        (dec_insn),
   .next_fetch_addr (next_fetch_addr),
   .upd_valid       (upd_valid),
   .upd_taken       (upd_taken),
   .upd_branch_addr (upd_branch_addr),
   .upd_target_insn (upd_target_insn),
   .upd_cont_addr   (upd_cont_addr),
   .lk_match        (lk_match)
);

// File: tb/taken_path_cache_tb.sv
module taken_path_cache_tb_top;

   localparam int CLK_P = 10;
   localparam int N     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic [31:0] ic_insn = '0;
   logic [31:0] seq_next_addr = '0;
   logic        hit;
   logic [31:0] dec_insn;
   logic [31:0] next_fetch_addr;
   logic        upd_valid = 1'b0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_branch_addr = '0;
   logic [31:0] upd_target_insn = '0;
   logic [31:0] upd_cont_addr = '0;

   int total = 0;
   int fails = 0;

   // bench model of the slots
   logic        mv [N];
   logic [31:0] ma [N];
   logic [31:0] mi [N];
   logic [31:0] mc [N];
   int          mp;

   always #(CLK_P/2) clk = ~clk;

   taken_path_cache #(.ENTRIES(N), .ADDR_W(32), .INSN_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .ic_insn(ic_insn),
      .seq_next_addr(seq_next_addr), .hit(hit), .dec_insn(dec_insn),
      .next_fetch_addr(next_fetch_addr), .upd_valid(upd_valid), .upd_taken(upd_taken),
      .upd_branch_addr(upd_branch_addr), .upd_target_insn(upd_target_insn),
      .upd_cont_addr(upd_cont_addr)
   );

   function automatic int mfind(input logic [31:0] a);
      for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
      return -1;
   endfunction

   function automatic logic [31:0] da(input int i);
      return 32'h0000_1000 + 32'(i) * 32'd8;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      upd_valid = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < N; i++) mv[i] = 1'b0;
      mp = 0;
      rst_n = 1'b1;
   endtask

   // one cycle: drive at negedge, check before posedge, update model after posedge
   task automatic cyc(input logic [31:0] fa, input logic uv, input logic ut,
                      input logic [31:0] ua, input logic [31:0] ui, input logic [31:0] uc,
                      input string tag_hit, input string tag_miss);
      int k;
      logic [31:0] icw;
      logic [31:0] sq;
      icw = $urandom;
      sq  = $urandom;
      fetch_addr = fa; ic_insn = icw; seq_next_addr = sq;
      upd_valid = uv; upd_taken = ut; upd_branch_addr = ua;
      upd_target_insn = ui; upd_cont_addr = uc;
      #(CLK_P/4);
      k = mfind(fa);
      if (k >= 0) begin
         chk(tag_hit, "hit", 32'(hit), 32'd1);
         chk(tag_hit, "dec_insn", dec_insn, mi[k]);
         chk(tag_hit, "next_fetch_addr", next_fetch_addr, mc[k]);
      end else begin
         chk(tag_miss, "hit", 32'(hit), 32'd0);
         chk(tag_miss, "dec_insn", dec_insn, icw);
         chk(tag_miss, "next_fetch_addr", next_fetch_addr, sq);
      end
      @(posedge clk);
      if (uv) begin
         k = mfind(ua);
         if (ut) begin
            if (k < 0) begin k = mp; mp = (mp + 1) % N; end
            mv[k] = 1'b1; ma[k] = ua; mi[k] = ui; mc[k] = uc;
         end else if (k >= 0) begin
            mv[k] = 1'b0;
         end
      end
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic look(input logic [31:0] fa, input string th, input string tm);
      cyc(fa, 1'b0, 1'b0, '0, '0, '0, th, tm);
   endtask

   task automatic put(input logic [31:0] a, input logic t, input string th, input string tm);
      cyc(32'hFFFF_FFF0, 1'b1, t, a, $urandom, $urandom, th, tm);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      total++;
      fails++;
      $display("FAIL R1 watchdog: actual=expired expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R1 / R2: empty after reset, transparent on miss
      for (int i = 0; i < N; i++) look(da(i), "R1", "R1");
      look(32'h1234_5678, "R2", "R2");

      // R11 / R3: four distinct branches all held
      for (int i = 0; i < N; i++) put(da(i), 1'b1, "R3", "R2");
      for (int i = 0; i < N; i++) look(da(i), "R11", "R11");

      // R9: same-cycle update not forwarded; R8: slot 0 (da0) evicted
      begin
         logic [31:0] w;
         w = $urandom;
         cyc(da(4), 1'b1, 1'b1, da(4), w, w ^ 32'h5A5A, "R9", "R9");
      end
      look(da(4), "R3", "R8");
      look(da(0), "R8", "R8");
      look(da(1), "R8", "R8");

      // R7: rewrite in place, nothing evicted, new data returned
      put(da(1), 1'b1, "R7", "R7");
      for (int i = 1; i <= N; i++) look(da(i), "R7", "R7");

      // R5: drop da2, neighbours kept
      put(da(2), 1'b0, "R5", "R5");
      look(da(2), "R5", "R5");
      look(da(3), "R5", "R5");
      // R6: drop of an absent address changes nothing
      put(da(9), 1'b0, "R6", "R6");
      for (int i = 1; i <= N; i++) look(da(i), "R6", "R6");

      // R4: single-bit difference misses
      look(da(3) ^ 32'h1, "R4", "R4");
      look(da(3) ^ 32'h8000_0000, "R4", "R4");

      // R8: pointer sits at slot 1 (da1), freed slot 2 not preferred
      put(da(5), 1'b1, "R8", "R8");
      look(da(1), "R8", "R8");
      look(da(5), "R8", "R8");

      // R10: repeated taken updates keep one copy; one drop removes it
      put(da(6), 1'b1, "R10", "R10");
      put(da(6), 1'b1, "R10", "R10");
      put(da(6), 1'b1, "R10", "R10");
      put(da(6), 1'b0, "R10", "R10");
      look(da(6), "R10", "R10");

      // random traffic over a small address pool
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] fa;
         logic [31:0] ua;
         logic        uv;
         logic        ut;
         fa = ($urandom % 8 == 0) ? $urandom : 32'h4000 + ($urandom % 8) * 4;
         ua = 32'h4000 + ($urandom % 8) * 4;
         uv = ($urandom % 2) == 0;
         ut = ($urandom % 5) < 3;
         cyc(fa, uv, ut, ua, $urandom, $urandom, "R3", "R2");
      end

      // R1: reset mid-run empties everything
      do_reset();
      for (int a = 0; a < 8; a++) look(32'h4000 + 32'(a) * 4, "R1", "R1");

      summary();
   end

endmodule